// File: doc/BRIEF.md
# Cascadable BCD Decade Counter

A 4-bit synchronous counter that steps through the decimal digits 0 to 9 in 8421 weighted code on each rising clock edge. Its value changes in one of four ways, and a fixed priority picks the way: clear, load a digit from a data input, count up, or hold. There are two count-enable inputs. Counting happens only when both are high, and the second enable also gates the terminal-count output.

The terminal-count output is combinational. When it is tied to the second count enable of the next stage, and every stage shares the clock and the first enable, the stages form a multi-digit decimal counter. A build-time parameter selects how reset behaves. In one variant the active-low reset clears the register at once, with no clock edge. In the other variant reset is decoded as the highest-priority synchronous mode. If the register is loaded with one of the six codes above 9, it returns to a valid digit within two counting edges.

Top module: `bcd_decade_counter`

## Requirements
- R1: While counting, the digit at count_o (8421 code, bit 3 most significant) advances by one per rising edge through 0..9, and 9 is followed by 0.
- R2: While counting from an unused code, the sequence is 10→11, 11→6, 12→13, 13→4, 14→15, 15→2, so a valid digit is reached in at most two edges.
- R3: With ASYNC_RST=1, rst_ni low clears count_o to 0 immediately, without a clock edge, whatever the other inputs are.
- R4: With ASYNC_RST=0, rst_ni low leaves count_o unchanged until the next rising edge and then clears it to 0, taking priority over load and count. In both variants, count_o is 0 one edge after rst_ni is sampled low.
- R5: With reset inactive, load_ni low loads data_i (any value 0..15) on the next rising edge, whatever the count enables are.
- R6: With reset inactive and load_ni high, the counter advances only when cnt_en_p_i and cnt_en_t_i are both high. Otherwise count_o holds.
- R7: tc_o is high exactly when cnt_en_t_i is high and count_o is 9. It follows those inputs combinationally and does not depend on cnt_en_p_i or load_ni.
- R8: When each stage's tc_o drives the next stage's cnt_en_t_i, two stages count 00 to 99 and then wrap to 00. Pulling the low stage's cnt_en_t_i low freezes both stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Active-low reset (asynchronous or synchronous, set by ASYNC_RST) |
| load_ni | input | 1 | Active-low parallel load |
| data_i | input | 4 | Digit to load |
| cnt_en_p_i | input | 1 | Count enable, counting only |
| cnt_en_t_i | input | 1 | Count enable, also gates tc_o |
| count_o | output | 4 | Present digit, 8421 code |
| tc_o | output | 1 | Terminal count for cascading |

## Verification
Loads, counts, holds and the synchronous clear all take effect at the first rising edge after the stimulus, through the single state register. The bench therefore sets inputs 2 ns after an edge and checks count_o 2 ns after the following edge. tc_o and the asynchronous clear do not wait for an edge. The bench checks them 1 ns after it changes the inputs, in the same cycle, and compares them there with the synchronous variant, which has not cleared yet. In the two-stage cascade, the carry passes through the low stage's tc_o within the cycle, so the two-digit value is checked once per edge.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  localparam int unsigned DIGIT_W  = 4;
  localparam int unsigned TOP_CODE = 9;

  typedef logic [DIGIT_W-1:0] digit_t;

  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_COUNT = 2'd1,
    MODE_LOAD  = 2'd2,
    MODE_CLEAR = 2'd3
  } mode_e;
endpackage

// File: rtl/bcd_mode_sel.sv
module bcd_mode_sel
  import bcd_pkg::*;
(
  input  logic  clr_i,
  input  logic  load_ni,
  input  logic  en_p_i,
  input  logic  en_t_i,
  output mode_e mode_o
);
  always_comb begin
    if (clr_i)                 mode_o = MODE_CLEAR;
    else if (!load_ni)         mode_o = MODE_LOAD;
    else if (en_p_i && en_t_i) mode_o = MODE_COUNT;
    else                       mode_o = MODE_HOLD;
  end
endmodule

// File: rtl/bcd_next_digit.sv
module bcd_next_digit
  import bcd_pkg::*;
(
  input  mode_e  mode_i,
  input  digit_t cur_i,
  input  digit_t data_i,
  output digit_t nxt_o
);
  // per-bit toggle terms; unused codes fall back into range in <=2 steps
  function automatic digit_t step(digit_t q);
    digit_t t;
    t[0] = 1'b1;
    t[1] = q[0] & ~q[3];
    t[2] = q[0] & q[1];
    t[3] = (q[0] & q[1] & q[2]) | (q[0] & q[3]);
    return q ^ t;
  endfunction

  always_comb begin
    unique case (mode_i)
      MODE_CLEAR: nxt_o = '0;
      MODE_LOAD:  nxt_o = data_i;
      MODE_COUNT: nxt_o = step(cur_i);
      default:    nxt_o = cur_i;
    endcase
  end
endmodule

// File: rtl/bcd_state_reg.sv
module bcd_state_reg
  import bcd_pkg::*;
#(
  parameter bit ASYNC_RST = 1'b1
) (
  input  logic   clk_i,
  input  logic   arst_ni,
  input  digit_t d_i,
  output digit_t q_o
);
  generate
    if (ASYNC_RST) begin : g_async
      always_ff @(posedge clk_i or negedge arst_ni) begin
        if (!arst_ni) q_o <= '0;
        else          q_o <= d_i;
      end
    end else begin : g_sync
      // arst_ni is tied high by the top in this variant
      always_ff @(posedge clk_i) begin
        if (!arst_ni) q_o <= '0;
        else          q_o <= d_i;
      end
    end
  endgenerate
endmodule

// File: rtl/bcd_tc_gen.sv
module bcd_tc_gen
  import bcd_pkg::*;
(
  input  digit_t cur_i,
  input  logic   en_t_i,
  output logic   tc_o
);
  localparam digit_t LAST = digit_t'(TOP_CODE);
  assign tc_o = en_t_i & (cur_i == LAST);
endmodule

// File: rtl/bcd_decade_counter.sv
module bcd_decade_counter
  import bcd_pkg::*;
#(
  parameter bit ASYNC_RST = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_ni,
  input  logic [DIGIT_W-1:0] data_i,
  input  logic               cnt_en_p_i,
  input  logic               cnt_en_t_i,
  output logic [DIGIT_W-1:0] count_o,
  output logic               tc_o
);
  mode_e  mode;
  digit_t cur, nxt;
  logic   sync_clr, reg_rst_n;

  assign sync_clr  = ASYNC_RST ? 1'b0 : ~rst_ni;
  assign reg_rst_n = ASYNC_RST ? rst_ni : 1'b1;

  bcd_mode_sel u_mode (
    .clr_i   (sync_clr),
    .load_ni (load_ni),
    .en_p_i  (cnt_en_p_i),
    .en_t_i  (cnt_en_t_i),
    .mode_o  (mode)
  );

  bcd_next_digit u_next (
    .mode_i (mode),
    .cur_i  (cur),
    .data_i (data_i),
    .nxt_o  (nxt)
  );

  bcd_state_reg #(.ASYNC_RST(ASYNC_RST)) u_reg (
    .clk_i   (clk_i),
    .arst_ni (reg_rst_n),
    .d_i     (nxt),
    .q_o     (cur)
  );

  bcd_tc_gen u_tc (
    .cur_i  (cur),
    .en_t_i (cnt_en_t_i),
    .tc_o   (tc_o)
  );

  assign count_o = cur;
endmodule

// File: rtl/bcd_decade_counter_chk.sv
module bcd_decade_counter_chk
  import bcd_pkg::*;
#(
  parameter bit ASYNC_RST = 1'b1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               load_ni,
  input logic [DIGIT_W-1:0] data_i,
  input logic               cnt_en_p_i,
  input logic               cnt_en_t_i,
  input logic [DIGIT_W-1:0] count_o,
  input logic               tc_o
);
  logic counting;
  assign counting = load_ni && cnt_en_p_i && cnt_en_t_i;

  a_r1_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (counting && count_o == 4'd9) |=> count_o == 4'd0);

  a_r2_odd_unused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (counting && count_o > 4'd9 && count_o[0]) |=> count_o <= 4'd9);

  a_r2_even_unused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (counting && count_o > 4'd9 && !count_o[0]) |=> count_o == $past(count_o) + 4'd1);

  a_r4_reset_clears: assert property (@(posedge clk_i)
    !rst_ni |=> count_o == 4'd0);

  a_r5_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_ni |=> count_o == $past(data_i));

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !(cnt_en_p_i && cnt_en_t_i)) |=> $stable(count_o));

  a_r7_tc_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_en_t_i |-> !tc_o);

  a_r8_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_o && cnt_en_p_i && load_ni) |=> count_o == 4'd0);

  always @(negedge clk_i) begin
    if (ASYNC_RST && !rst_ni) begin
      a_r3_async_clear: assert (count_o == 4'd0);
    end
  end
endmodule

bind bcd_decade_counter bcd_decade_counter_chk #(.ASYNC_RST(ASYNC_RST)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .load_ni    (load_ni),
  .data_i     (data_i),
  .cnt_en_p_i (cnt_en_p_i),
  .cnt_en_t_i (cnt_en_t_i),
  .count_o    (count_o),
  .tc_o       (tc_o)
);

// File: tb/bcd_decade_counter_tb.sv
module bcd_decade_counter_tb;
  logic       clk = 1'b0;
  logic       rst_n, load_n, cep, cet;
  logic [3:0] data;
  logic [3:0] cnt_a, cnt_s;
  logic       tc_a, tc_s;
  logic       c_rst_n, c_en;
  logic [3:0] lo_cnt, hi_cnt;
  logic       lo_tc, hi_tc;
  int         n_run = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  bcd_decade_counter #(.ASYNC_RST(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .load_ni(load_n), .data_i(data),
    .cnt_en_p_i(cep), .cnt_en_t_i(cet), .count_o(cnt_a), .tc_o(tc_a));

  bcd_decade_counter #(.ASYNC_RST(1'b0)) u_sync (
    .clk_i(clk), .rst_ni(rst_n), .load_ni(load_n), .data_i(data),
    .cnt_en_p_i(cep), .cnt_en_t_i(cet), .count_o(cnt_s), .tc_o(tc_s));

  bcd_decade_counter #(.ASYNC_RST(1'b1)) u_lo (
    .clk_i(clk), .rst_ni(c_rst_n), .load_ni(1'b1), .data_i(4'd0),
    .cnt_en_p_i(1'b1), .cnt_en_t_i(c_en), .count_o(lo_cnt), .tc_o(lo_tc));

  bcd_decade_counter #(.ASYNC_RST(1'b1)) u_hi (
    .clk_i(clk), .rst_ni(c_rst_n), .load_ni(1'b1), .data_i(4'd0),
    .cnt_en_p_i(1'b1), .cnt_en_t_i(lo_tc), .count_o(hi_cnt), .tc_o(hi_tc));

  function automatic logic [3:0] next_code(logic [3:0] v);
    case (v)
      4'd9:    return 4'd0;
      4'd10:   return 4'd11;
      4'd11:   return 4'd6;
      4'd12:   return 4'd13;
      4'd13:   return 4'd4;
      4'd14:   return 4'd15;
      4'd15:   return 4'd2;
      default: return v + 4'd1;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      summary();
    end
  end

  initial begin
    logic [3:0] expv;
    rst_n = 1'b0; load_n = 1'b1; data = 4'd0; cep = 1'b0; cet = 1'b0;
    c_rst_n = 1'b0; c_en = 1'b0;
    tick(); tick();
    check(cnt_a == 4'd0, "R3 reset state", cnt_a, 0);
    check(cnt_s == 4'd0, "R4 reset state", cnt_s, 0);
    check(!tc_a && !tc_s, "R7 reset tc", tc_a, 0);
    rst_n = 1'b1;

    // every start code x every control pattern
    for (int s = 0; s < 16; s++) begin
      for (int m = 0; m < 8; m++) begin
        load_n = 1'b0; data = 4'(s); cep = m[0]; cet = m[1];
        tick();
        check(cnt_a == 4'(s), "R5 load async variant", cnt_a, s);
        check(cnt_s == 4'(s), "R5 load sync variant", cnt_s, s);
        load_n = m[2]; data = ~4'(s);
        #1;
        check(tc_a == (m[1] && s == 9), "R7 tc async variant", tc_a, int'(m[1] && s == 9));
        check(tc_s == (m[1] && s == 9), "R7 tc sync variant", tc_s, int'(m[1] && s == 9));
        if (!m[2])             expv = ~4'(s);
        else if (m[0] && m[1]) expv = next_code(4'(s));
        else                   expv = 4'(s);
        tick();
        if (!m[2])                check(cnt_a == expv && cnt_s == expv, "R5 load over enables", cnt_a, expv);
        else if (!(m[0] && m[1])) check(cnt_a == expv && cnt_s == expv, "R6 hold", cnt_a, expv);
        else if (s > 9)           check(cnt_a == expv && cnt_s == expv, "R2 unused code step", cnt_a, expv);
        else                      check(cnt_a == expv && cnt_s == expv, "R1 count step", cnt_a, expv);
      end
    end

    // full decade run with wrap
    load_n = 1'b0; data = 4'd0; cep = 1'b1; cet = 1'b1;
    tick();
    load_n = 1'b1;
    for (int i = 1; i <= 12; i++) begin
      tick();
      check(cnt_a == 4'(i % 10), "R1 decade run", cnt_a, i % 10);
      check(cnt_s == 4'(i % 10), "R1 decade run sync", cnt_s, i % 10);
    end

    // reset precedence over load and count
    load_n = 1'b0; data = 4'd5;
    tick();
    rst_n = 1'b0; load_n = 1'b0; data = 4'd7; cep = 1'b1; cet = 1'b1;
    #1;
    check(cnt_a == 4'd0, "R3 immediate clear", cnt_a, 0);
    check(cnt_s == 4'd5, "R4 no clear before edge", cnt_s, 5);
    tick();
    check(cnt_s == 4'd0, "R4 clear beats load", cnt_s, 0);
    check(cnt_a == 4'd0, "R3 held clear", cnt_a, 0);
    rst_n = 1'b1; load_n = 1'b1;

    // asynchronous clear in mid-cycle while counting
    tick(); tick(); tick();
    check(cnt_a == 4'd3 && cnt_s == 4'd3, "R1 count after reset", cnt_a, 3);
    #1 rst_n = 1'b0;
    #1;
    check(cnt_a == 4'd0, "R3 mid-cycle clear", cnt_a, 0);
    check(cnt_s == 4'd3, "R4 mid-cycle no clear", cnt_s, 3);
    tick();
    check(cnt_s == 4'd0, "R4 clear at edge", cnt_s, 0);
    rst_n = 1'b1;

    // two-stage cascade 00..99
    c_rst_n = 1'b1; c_en = 1'b1;
    for (int i = 1; i <= 101; i++) begin
      check(hi_tc == ((i - 1) % 100 == 99), "R8 cascade tc", hi_tc, int'((i - 1) % 100 == 99));
      tick();
      check(int'(hi_cnt) * 10 + int'(lo_cnt) == i % 100, "R8 cascade value",
            int'(hi_cnt) * 10 + int'(lo_cnt), i % 100);
    end
    c_en = 1'b0;
    tick(); tick();
    check(hi_cnt == 4'd0 && lo_cnt == 4'd1, "R8 cascade freeze",
          int'(hi_cnt) * 10 + int'(lo_cnt), 1);

    done = 1'b1;
    summary();
  end
endmodule